// File: doc/BRIEF.md
# Keyed Error Escalation Watchdog

This block escalates a high-priority error that software has not dealt with in time. A down-counter sits loaded with a preload value. While the watchdog is enabled and the high-priority-error-active input is high, the counter counts down by one each clock. If the error is still present when the count reaches zero, the watchdog interrupt is raised. The interrupt stays raised until software clears it. A clear does not hold while the error is still present and the count is still at zero.

The enable field and the free-run field are 4-bit keys. Each one takes effect only when it holds 0xA, so a single flipped bit cannot turn the function on or off by accident. A debug suspend input freezes the counter unless the free-run key is armed. A lock input blocks writes to the configuration and the preload.

The block has two synchronous active-low resets. The power-on reset clears everything. The warm reset returns only the counter to its reset value, so the interrupt status survives a warm restart.

The register port has a write strobe, a 3-bit address, write data, and combinational read data. The addresses are:
- 0: config. Enable key in bits [3:0], free-run key in bits [7:4].
- 1: preload.
- 2: live counter, read only.
- 3: set view of the interrupt status.
- 4: clear view of the interrupt status.

Top module: `wdog_escalate`

## Requirements
- R1: After power-on reset, address 0 reads 0x0000000A (enable key 0xA in bits [3:0], free-run key 0x0 in bits [7:4]). The preload (address 1) and the counter (address 2) read 0x0000FFFF. The interrupt output is low.
- R2: The watchdog is enabled only while the enable key equals 0xA. With any other key value, the counter holds the preload and the interrupt is never raised by the count, even while the error input is high.
- R3: While the watchdog is enabled and the error input is low, the counter is reloaded with the preload on every clock edge.
- R4: While the watchdog is enabled, the error input is high, and the counter is not frozen, the counter drops by one per clock edge. It stays at zero once there.
- R5: While debug suspend is high, the counter holds its value. The exception is when the free-run key (bits [7:4] of address 0) equals 0xA; the counter then keeps counting.
- R6: The interrupt output rises on the clock edge after the counter sits at zero with the watchdog enabled and the error input high. With preload P and the error input held high from edge k, the counter reaches zero at edge k+P-1 and the interrupt rises at edge k+P.
- R7: Writing data with bit 0 set to address 3 raises the interrupt. Writing data with bit 0 set to address 4 lowers it. A write with bit 0 clear has no effect. Addresses 3 and 4 both return the status in bit 0.
- R8: A clear written while the counter is at zero with the error still present and the watchdog enabled leaves the interrupt high.
- R9: While the lock input is high, writes to address 0 and address 1 are ignored.
- R10: The warm reset returns the counter to 0xFFFF and leaves the interrupt status, config and preload unchanged. The power-on reset restores all of them to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| warm_n | input | 1 | Warm reset, synchronous, active low, counter only |
| err_act | input | 1 | An enabled high-priority error is pending |
| dbg_susp | input | 1 | Debug suspend request |
| cfg_lock | input | 1 | Blocks writes to config and preload |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| wd_irq | output | 1 | Watchdog interrupt |

## Verification
A wrong key decode or a wrong freeze decision shows on the counter readback within one clock edge. The count either moves when it should hold, or holds when it should move. An off-by-one in the reload or the decrement shifts the rising edge of the interrupt by one edge. The bench therefore samples the interrupt exactly one edge before and at the expected edge. A mix-up between the two resets shows right after a warm reset pulse, as a lost interrupt or a changed preload. The R8 case is checked within a single register write.

// File: rtl/wdog_pkg.sv
// Package: shared register addresses and key constant for the escalation watchdog.
// Assumes a 3-bit register address and 4-bit keys.
package wdog_pkg;
    localparam logic [3:0] KEY_ARMED = 4'hA;

    localparam logic [2:0] A_CFG     = 3'd0;
    localparam logic [2:0] A_PRELOAD = 3'd1;
    localparam logic [2:0] A_COUNT   = 3'd2;
    localparam logic [2:0] A_SETV    = 3'd3;
    localparam logic [2:0] A_CLRV    = 3'd4;

    typedef struct packed {
        logic [3:0] free_key;
        logic [3:0] en_key;
    } wdog_cfg_t;
endpackage

// File: rtl/wdog_cfg_regs.sv
// Config and preload registers.
// Writes are dropped while the lock input is high.
// Reset by power-on reset only.
// Decodes both keys into single-bit qualifiers.
module wdog_cfg_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int PRELOAD_RST = 32'hFFFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              lock,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output wdog_cfg_t         cfg,
    output logic [CNT_W-1:0]  preload,
    output logic              wd_on,
    output logic              free_on
);
    wdog_cfg_t        cfg_q;
    logic [CNT_W-1:0] pre_q;
    logic             wr_ok;

    assign wr_ok = we && !lock;

    // Config register: key write under lock.
    always_ff @(posedge clk) begin
        if (!por_n)
            cfg_q <= '{free_key: 4'h0, en_key: KEY_ARMED};
        else if (wr_ok && addr == A_CFG)
            cfg_q <= wdog_cfg_t'(wdata[7:0]);
    end

    // Preload register: value write under lock.
    always_ff @(posedge clk) begin
        if (!por_n)
            pre_q <= CNT_W'(PRELOAD_RST);
        else if (wr_ok && addr == A_PRELOAD)
            pre_q <= wdata[CNT_W-1:0];
    end

    assign cfg     = cfg_q;
    assign preload = pre_q;
    assign wd_on   = (cfg_q.en_key == KEY_ARMED);
    assign free_on = (cfg_q.free_key == KEY_ARMED);

    AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!por_n)
        (lock && we) |=> $stable(cfg_q)) else $error("lock cfg"); // R9
    AST_LOCK_PRE: assert property (@(posedge clk) disable iff (!por_n)
        (lock && we) |=> $stable(pre_q)) else $error("lock preload"); // R9
endmodule

// File: rtl/wdog_counter.sv
// Down-counter with reload.
// Reloads while idle or disabled, freezes under debug suspend unless free-run is armed,
// and saturates at zero.
// rst_n combines the power-on and warm resets.
module wdog_counter #(
    parameter int CNT_W   = 32,
    parameter int CNT_RST = 32'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_on,
    input  logic             free_on,
    input  logic             err_act,
    input  logic             dbg_susp,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed;
    logic             frozen;

    assign armed  = wd_on && err_act;
    assign frozen = dbg_susp && !free_on;

    // Count register: reload, hold or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(CNT_RST);
        else if (!armed)
            cnt_q <= preload;
        else if (!frozen && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count  = cnt_q;
    assign expire = armed && (cnt_q == '0);

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_on && err_act) |=> (cnt_q == $past(preload))) else $error("reload"); // R3
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && err_act && dbg_susp && !free_on) |=> $stable(cnt_q)) else $error("freeze"); // R5
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && err_act && !(dbg_susp && !free_on) && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("step"); // R4
endmodule

// File: rtl/wdog_irq_status.sv
// Interrupt status bit.
// Set by expiry or a software set write; cleared by a software clear write.
// Expiry wins over a clear.
// Reset by power-on reset only.
module wdog_irq_status (
    input  logic clk,
    input  logic por_n,
    input  logic expire,
    input  logic sw_set,
    input  logic sw_clr,
    output logic irq
);
    logic irq_q;

    // Status flop: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!por_n)
            irq_q <= 1'b0;
        else if (expire || sw_set)
            irq_q <= 1'b1;
        else if (sw_clr)
            irq_q <= 1'b0;
    end

    assign irq = irq_q;

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> irq_q) else $error("expire"); // R6
    AST_SW_SET: assert property (@(posedge clk) disable iff (!por_n)
        sw_set |=> irq_q) else $error("set"); // R7
    AST_SW_CLR: assert property (@(posedge clk) disable iff (!por_n)
        (sw_clr && !expire && !sw_set) |=> !irq_q) else $error("clear"); // R7
endmodule

// File: rtl/wdog_escalate.sv
// Top of the keyed escalation watchdog.
// Ties the config registers, the counter and the status bit together,
// and provides the register read mux.
// Assumes synchronous active-low resets.
module wdog_escalate
    import wdog_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int PRELOAD_RST = 32'hFFFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              err_act,
    input  logic              dbg_susp,
    input  logic              cfg_lock,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wd_irq
);
    wdog_cfg_t        cfg;
    logic [CNT_W-1:0] preload;
    logic [CNT_W-1:0] count;
    logic             wd_on;
    logic             free_on;
    logic             expire;
    logic             cnt_rst_n;
    logic             sw_set;
    logic             sw_clr;

    assign cnt_rst_n = por_n && warm_n;
    assign sw_set    = reg_we && reg_addr == A_SETV && reg_wdata[0];
    assign sw_clr    = reg_we && reg_addr == A_CLRV && reg_wdata[0];

    wdog_cfg_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PRELOAD_RST(PRELOAD_RST)
    ) u_cfg (
        .clk(clk), .por_n(por_n), .lock(cfg_lock), .we(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg), .preload(preload),
        .wd_on(wd_on), .free_on(free_on)
    );

    wdog_counter #(
        .CNT_W(CNT_W), .CNT_RST(PRELOAD_RST)
    ) u_cnt (
        .clk(clk), .rst_n(cnt_rst_n), .wd_on(wd_on), .free_on(free_on),
        .err_act(err_act), .dbg_susp(dbg_susp), .preload(preload),
        .count(count), .expire(expire)
    );

    wdog_irq_status u_irq (
        .clk(clk), .por_n(por_n), .expire(expire),
        .sw_set(sw_set), .sw_clr(sw_clr), .irq(wd_irq)
    );

    // Read mux: both status views return the same bit.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:           reg_rdata = DATA_W'(cfg);
            A_PRELOAD:       reg_rdata = DATA_W'(preload);
            A_COUNT:         reg_rdata = DATA_W'(count);
            A_SETV, A_CLRV:  reg_rdata = DATA_W'(wd_irq);
            default:         reg_rdata = '0;
        endcase
    end

    AST_WARM_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_n && wd_irq) |=> wd_irq) else $error("warm irq"); // R10
endmodule

// File: tb/sim_wdog_escalate.sv
module sim_wdog_escalate;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, warm_n = 1'b1;
    logic        err_act = 1'b0, dbg_susp = 1'b0, cfg_lock = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wd_irq;
    int          n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    wdog_escalate u0 (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .err_act(err_act),
        .dbg_susp(dbg_susp), .cfg_lock(cfg_lock), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_irq(wd_irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg", 3'd0, 32'h0000000A);
        rd_chk("R1 preload", 3'd1, 32'h0000FFFF);
        rd_chk("R1 count", 3'd2, 32'h0000FFFF);
        chk("R1 irq", {31'd0, wd_irq}, 32'd0);
    endtask

    task automatic t_reload_count_expire;
        wr(3'd1, 32'd5);
        step(1);
        rd_chk("R3 reload idle", 3'd2, 32'd5);
        err_act = 1'b1;
        step(2);
        rd_chk("R4 decrement", 3'd2, 32'd3);
        step(3);
        rd_chk("R4 reach zero", 3'd2, 32'd0);
        chk("R6 not yet", {31'd0, wd_irq}, 32'd0);
        step(1);
        chk("R6 raised", {31'd0, wd_irq}, 32'd1);
        rd_chk("R4 saturate", 3'd2, 32'd0);
    endtask

    task automatic t_clear_persist;
        wr(3'd4, 32'd1);
        chk("R8 clear ignored while cause", {31'd0, wd_irq}, 32'd1);
        err_act = 1'b0;
        step(1);
        rd_chk("R3 reload after drop", 3'd2, 32'd5);
        wr(3'd4, 32'd1);
        chk("R7 clear", {31'd0, wd_irq}, 32'd0);
    endtask

    task automatic t_sw_views;
        wr(3'd3, 32'd0);
        chk("R7 set with 0 no effect", {31'd0, wd_irq}, 32'd0);
        wr(3'd3, 32'd1);
        rd_chk("R7 set view", 3'd3, 32'd1);
        rd_chk("R7 clear view", 3'd4, 32'd1);
        wr(3'd4, 32'd0);
        chk("R7 clear with 0 no effect", {31'd0, wd_irq}, 32'd1);
        wr(3'd4, 32'd1);
        rd_chk("R7 cleared view", 3'd3, 32'd0);
    endtask

    task automatic t_key_disable;
        wr(3'd0, 32'h05);
        err_act = 1'b1;
        step(8);
        rd_chk("R2 key 0x5 holds", 3'd2, 32'd5);
        chk("R2 no irq", {31'd0, wd_irq}, 32'd0);
        wr(3'd0, 32'h0B);
        step(3);
        rd_chk("R2 key 0xB holds", 3'd2, 32'd5);
        err_act = 1'b0;
        wr(3'd0, 32'h0A);
    endtask

    task automatic t_suspend;
        dbg_susp = 1'b1; err_act = 1'b1;
        step(3);
        rd_chk("R5 frozen", 3'd2, 32'd5);
        wr(3'd0, 32'hAA);
        step(2);
        rd_chk("R5 free-run counts", 3'd2, 32'd3);
        err_act = 1'b0; dbg_susp = 1'b0;
        step(1);
    endtask

    task automatic t_lock;
        cfg_lock = 1'b1;
        wr(3'd1, 32'd9);
        wr(3'd0, 32'h05);
        rd_chk("R9 preload kept", 3'd1, 32'd5);
        rd_chk("R9 cfg kept", 3'd0, 32'hAA);
        cfg_lock = 1'b0;
    endtask

    task automatic t_resets;
        wr(3'd3, 32'd1);
        err_act = 1'b1;
        step(2);
        rd_chk("R4 before warm", 3'd2, 32'd3);
        warm_n = 1'b0;
        step(1);
        rd_chk("R10 warm count", 3'd2, 32'h0000FFFF);
        chk("R10 warm keeps irq", {31'd0, wd_irq}, 32'd1);
        rd_chk("R10 warm keeps preload", 3'd1, 32'd5);
        rd_chk("R10 warm keeps cfg", 3'd0, 32'hAA);
        warm_n = 1'b1; err_act = 1'b0;
        por_n = 1'b0;
        step(1);
        chk("R10 por irq", {31'd0, wd_irq}, 32'd0);
        rd_chk("R10 por cfg", 3'd0, 32'h0A);
        rd_chk("R10 por preload", 3'd1, 32'h0000FFFF);
        por_n = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        n_err++;
        $display("FAIL watchdog timeout");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(2);
        por_n = 1'b1;
        t_reset();
        t_reload_count_expire();
        t_clear_persist();
        t_sw_views();
        t_key_disable();
        t_suspend();
        t_lock();
        t_resets();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule